// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs external memory cycles over a shared 16-bit address/data bus. A core-side request carries a word address, write data, two byte-lane enables, a direction bit and an instruction-fetch flag. The controller drives the address in the first clock of a cycle and marks it with an address strobe. It then turns the bus around for read data or drives write data, and lowers the read or write strobes in a timed window. When the cycle ends it returns the assembled read data with a one-cycle completion pulse.

One bus cycle is four clocks. The second half of the cycle (two clocks) can be repeated as wait states while the ready input is low. The strobe can run as a short latch pulse or as a level that is held low for the body of the cycle. Byte writes can be marked in two ways: a whole-cycle high-byte enable with a common write strobe, or separate low-byte and high-byte write strobes. The bus width is either fixed by configuration or sampled on every cycle from a width pin. On an 8-bit cycle, a two-byte access is split into two consecutive byte cycles.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Out of reset and while `busy_o` is 0, the outputs are `rd_n_o`=1, `wr_n_o`=1, `bhe_n_o`=1, `inst_o`=0, `ad_oe_o`=0 and `done_o`=0. `as_o` is 0 when `cfg_adv`=0 and 1 when `cfg_adv`=1.
- R2: A request is accepted on a rising edge where `req_i`=1 and `busy_o`=0. Each byte or word cycle is 4 clocks, numbered 0 to 3. In clock 0, `ad_oe_o`=1 and `ad_o` carries {address[15:1], A0}, where A0 is 1 for the second byte cycle of a split and for a request with `req_be`=2'b10, and 0 otherwise. `done_o` is high for exactly one clock, in the clock after the final cycle, and `busy_o` is 0 in that clock.
- R3: With `cfg_adv`=0, `as_o` is high only in clock 0 of each cycle. With `cfg_adv`=1, `as_o` is high when idle and in clock 0, and low from clock 1 to the end of the cycle. In both modes its falling edge marks the point where the address is valid.
- R4: On a read, `ad_oe_o` is 0 from clock 1 on. `rd_n_o` is low in clocks 2 and 3 and in every wait state. `ad_i` is sampled at the end of clock 3 and returned on `rdata_o` together with `done_o`.
- R5: On a write, `ad_oe_o` stays 1 and `ad_o` carries the write data from clock 1 to the end of the cycle.
- R6: With `cfg_wstb`=0, `wr_n_o` is low in clocks 2 and 3 (and in wait states) of every write. `bhe_n_o` is low from clock 1 to the end of any write cycle that carries the odd (high) byte.
- R7: With `cfg_wstb`=1, `wr_n_o` is low in the strobe window only for cycles that write the even (low) byte. `bhe_n_o` is low in the same window only for cycles that write the odd byte.
- R8: `cfg_wid` sets the width: 2'b01 gives 16-bit, 2'b00 and 2'b10 give 8-bit, and 2'b11 samples `bw_i` at the end of clock 0 of each cycle (1 = 16-bit, 0 = 8-bit).
- R9: An 8-bit cycle with `req_be`=2'b11 runs as two back-to-back byte cycles, even byte first and then odd byte. Each byte moves on `ad_o[7:0]` / `ad_i[7:0]`, and read bytes land in their own lane of `rdata_o`. An unselected lane reads 0. A 16-bit read returns all of `ad_i`.
- R10: If `rdy_i` is 0 at the end of clock 3, clocks 2 and 3 are repeated. Each wait adds 2 clocks, and waits continue until `rdy_i` is 1 at the end of clock 3.
- R11: `inst_o` is high in every clock of every cycle of a request with `req_fetch`=1, and low for other requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (oscillator rate) |
| rst_n | input | 1 | Active-low reset |
| cfg_adv | input | 1 | Strobe mode: 0 latch pulse, 1 address-valid level |
| cfg_wstb | input | 1 | Write strobe encoding: 0 common write + high enable, 1 per-byte writes |
| cfg_wid | input | 2 | Bus width selection |
| req_i | input | 1 | Request valid |
| req_addr | input | 15 | Word address, bits 15..1 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lanes, bit 0 even byte, bit 1 odd byte |
| req_wr | input | 1 | 1 write, 0 read |
| req_fetch | input | 1 | Instruction fetch flag |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data |
| as_o | output | 1 | Address strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write / low-byte write strobe, active low |
| bhe_n_o | output | 1 | High-byte enable / high-byte write strobe, active low |
| inst_o | output | 1 | Instruction fetch indicator |
| ad_o | output | 16 | Address/data bus out |
| ad_oe_o | output | 1 | Bus output enable |
| ad_i | input | 16 | Address/data bus in |
| rdy_i | input | 1 | Ready, low inserts wait states |
| bw_i | input | 1 | Bus width pin |

## Verification
The bench measures the latency of each access and counts the clocks in which each strobe is low. A controller that drops wait-state repeats, or that adds only one clock per wait, shows up as a latency or `rd_n_o` count that is off by one or two. Split 8-bit accesses are checked for even-before-odd order, using the first and last latched addresses and the lane placement of read bytes. A swapped order or a wrong lane returns byte data that does not match the memory model. The two write-strobe encodings are run against the same requests, so a `bhe_n_o` that covers the wrong clocks, or a `wr_n_o` that ignores the lane, changes the counted low clocks. The width pin is tested in both states under per-cycle mode, which catches a controller that ignores it or samples it too late.

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_adv,
  input  logic        cfg_wstb,
  input  logic [1:0]  cfg_wid,
  input  logic        req_i,
  input  logic [15:1] req_addr,
  input  logic [15:0] req_wdata,
  input  logic [1:0]  req_be,
  input  logic        req_wr,
  input  logic        req_fetch,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        as_o,
  output logic        rd_n_o,
  output logic        wr_n_o,
  output logic        bhe_n_o,
  output logic        inst_o,
  output logic [15:0] ad_o,
  output logic        ad_oe_o,
  input  logic [15:0] ad_i,
  input  logic        rdy_i,
  input  logic        bw_i
);

  logic        act, second, w16, wr_q, fetch_q, done_q;
  logic [1:0]  ph, be_q;
  logic [15:1] addr_q;
  logic [15:0] wd_q, rd_q;

  wire cur_hi = second | (be_q == 2'b10);
  wire lo_b   = w16 ? be_q[0] : !cur_hi;
  wire hi_b   = w16 ? be_q[1] : cur_hi;
  wire body   = act & (ph != 2'd0);
  wire win    = act & ph[1];
  wire more   = !w16 & (be_q == 2'b11) & !second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; second <= 1'b0; w16 <= 1'b0; wr_q <= 1'b0; fetch_q <= 1'b0;
      done_q <= 1'b0; ph <= 2'd0; be_q <= 2'b00; addr_q <= '0; wd_q <= '0; rd_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act) begin
        if (req_i) begin
          act <= 1'b1; ph <= 2'd0; second <= 1'b0; rd_q <= '0;
          addr_q <= req_addr; wd_q <= req_wdata; be_q <= req_be;
          wr_q <= req_wr; fetch_q <= req_fetch;
        end
      end else begin
        case (ph)
          2'd0: begin
            w16 <= (cfg_wid == 2'b11) ? bw_i : (cfg_wid == 2'b01);
            ph  <= 2'd1;
          end
          2'd1: ph <= 2'd2;
          2'd2: ph <= 2'd3;
          default: begin
            if (!rdy_i) ph <= 2'd2;
            else begin
              if (!wr_q) begin
                if (w16)         rd_q <= ad_i;
                else if (cur_hi) rd_q[15:8] <= ad_i[7:0];
                else             rd_q[7:0]  <= ad_i[7:0];
              end
              if (more) begin
                second <= 1'b1;
                ph     <= 2'd0;
              end else begin
                act    <= 1'b0;
                done_q <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign busy_o  = act;
  assign done_o  = done_q;
  assign rdata_o = rd_q;
  assign as_o    = cfg_adv ? !body : (act & (ph == 2'd0));
  assign rd_n_o  = !(win & !wr_q);
  assign wr_n_o  = !(win & wr_q & (!cfg_wstb | lo_b));
  assign bhe_n_o = cfg_wstb ? !(win & wr_q & hi_b) : !(body & wr_q & hi_b);
  assign inst_o  = act & fetch_q;
  assign ad_oe_o = act & ((ph == 2'd0) | wr_q);
  assign ad_o    = !body ? {addr_q, cur_hi}
                 : (w16 ? wd_q : {wd_q[15:8], cur_hi ? wd_q[15:8] : wd_q[7:0]});

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (rd_n_o && wr_n_o && bhe_n_o && !inst_o && !ad_oe_o)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2
  AST_ADV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_adv && busy_o && ph == 2'd1) |=> !as_o); // R3
  AST_WAIT_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (act && ph == 2'd3 && !rdy_i) |=> (act && ph == 2'd2 && $stable(ad_o))); // R10
  AST_INST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ph != 2'd0) |-> $stable(inst_o)); // R11

endmodule

// File: tb/ext_bus_ctrl_tb.sv
module ext_bus_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_adv = 0, cfg_wstb = 0, req_i = 0, req_wr = 0, req_fetch = 0, rdy_i = 1, bw_i = 0;
  logic [1:0] cfg_wid = 2'b01, req_be = 2'b11;
  logic [15:1] req_addr = '0;
  logic [15:0] req_wdata = '0, ad_i, rdata_o, ad_o;
  logic busy_o, done_o, as_o, rd_n_o, wr_n_o, bhe_n_o, inst_o, ad_oe_o;
  logic [15:0] la = '0;
  logic wide_e = 1;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ext_bus_ctrl u_dut (.clk(clk), .rst_n(rst_n), .cfg_adv(cfg_adv), .cfg_wstb(cfg_wstb),
    .cfg_wid(cfg_wid), .req_i(req_i), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .req_wr(req_wr), .req_fetch(req_fetch), .busy_o(busy_o),
    .done_o(done_o), .rdata_o(rdata_o), .as_o(as_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .bhe_n_o(bhe_n_o), .inst_o(inst_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i),
    .rdy_i(rdy_i), .bw_i(bw_i));

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(negedge clk) if (as_o) la = ad_o;
  assign ad_i = {mb({la[15:1], 1'b1}), wide_e ? mb({la[15:1], 1'b0}) : mb(la)};

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic adv; logic ws; logic [1:0] wid; logic bw; logic wr; logic fetch;
    logic [1:0] be; logic [1:0] w; logic [15:0] a; logic [15:0] d;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,2'b01,1'b0,1'b0,1'b1,2'b11,2'd0,16'h1234,16'h0000},
    '{1'b1,1'b0,2'b01,1'b0,1'b0,1'b0,2'b11,2'd2,16'h2200,16'h0000},
    '{1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,2'b11,2'd0,16'h3010,16'h0000},
    '{1'b0,1'b0,2'b00,1'b0,1'b1,1'b0,2'b11,2'd0,16'h4020,16'hA1B2},
    '{1'b0,1'b1,2'b00,1'b0,1'b1,1'b0,2'b11,2'd1,16'h4020,16'hA1B2},
    '{1'b0,1'b1,2'b01,1'b0,1'b1,1'b0,2'b10,2'd0,16'h5030,16'h77CC},
    '{1'b0,1'b1,2'b01,1'b0,1'b1,1'b0,2'b01,2'd0,16'h5030,16'h77CC},
    '{1'b1,1'b0,2'b11,1'b1,1'b0,1'b0,2'b11,2'd0,16'h6040,16'h0000},
    '{1'b1,1'b0,2'b11,1'b0,1'b0,1'b0,2'b11,2'd0,16'h6040,16'h0000},
    '{1'b0,1'b0,2'b10,1'b0,1'b0,1'b1,2'b10,2'd1,16'h7050,16'h0000},
    '{1'b0,1'b0,2'b11,1'b0,1'b1,1'b0,2'b01,2'd0,16'h7052,16'h1234}
  };

  task automatic run_vec(input vec_t v);
    int n, lat, e_rd, e_wr, e_bhe, c_rd, c_wr, c_bhe, c_as, c_inst, k_rdy;
    logic [15:0] e_first, e_last, e_wd, e_rdat, g_first, g_last, g_wd, ev;
    logic g_oe, idle_as;
    bit wide;
    wide = (v.wid == 2'b01) || (v.wid == 2'b11 && v.bw);
    n = (!wide && v.be == 2'b11) ? 2 : 1;
    lat = 4 * n + 2 * v.w;
    e_rd = 0; e_wr = 0; e_bhe = 0;
    for (int k = 0; k < n; k++) begin
      bit ab, evn, odd;
      int ex;
      ab  = (k == 1) || (v.be == 2'b10);
      evn = wide ? v.be[0] : !ab;
      odd = wide ? v.be[1] : ab;
      ex  = (k == 0) ? 2 * v.w : 0;
      if (!v.wr) e_rd += 2 + ex;
      if (v.wr && (!v.ws || evn)) e_wr += 2 + ex;
      if (v.wr && odd) e_bhe += (v.ws ? 2 : 3) + ex;
      if (k == 0) e_first = {v.a[15:1], ab};
      e_last = {v.a[15:1], ab};
    end
    ev = {v.a[15:1], 1'b0};
    e_wd = wide ? v.d : {v.d[15:8], e_first[0] ? v.d[15:8] : v.d[7:0]};
    if (wide) e_rdat = {mb(ev | 16'h1), mb(ev)};
    else e_rdat = {v.be[1] ? mb(ev | 16'h1) : 8'h00, v.be[0] ? mb(ev) : 8'h00};
    k_rdy = 3 + 2 * v.w;

    @(negedge clk);
    cfg_adv = v.adv; cfg_wstb = v.ws; cfg_wid = v.wid; bw_i = v.bw; wide_e = wide;
    req_addr = v.a[15:1]; req_wdata = v.d; req_be = v.be; req_wr = v.wr;
    req_fetch = v.fetch; rdy_i = (v.w == 0); req_i = 1;
    @(posedge clk);
    c_rd = 0; c_wr = 0; c_bhe = 0; c_as = 0; c_inst = 0;
    g_first = 'x; g_last = 'x; g_wd = 'x; g_oe = 0; idle_as = 0;
    lat = lat;
    begin : walk
      int i;
      for (i = 0; i < 60; i++) begin
        @(negedge clk);
        if (i == 0) req_i = 0;
        rdy_i = (i >= k_rdy);
        if (done_o) begin
          idle_as = as_o;
          break;
        end
        c_rd += !rd_n_o; c_wr += !wr_n_o; c_bhe += !bhe_n_o; c_as += as_o; c_inst += inst_o;
        if (i == 1) g_first = la;
        if (i == 2) begin g_wd = ad_o; g_oe = ad_oe_o; end
        if (i == lat - 1) g_last = la;
      end
      chk(i == lat, "R2/R10 latency", 16'(i), 16'(lat));
    end
    chk(c_as == n, "R3 strobe clocks", 16'(c_as), 16'(n));
    chk(idle_as == v.adv, "R3 idle strobe level", 16'(idle_as), 16'(v.adv));
    chk(g_first == e_first, "R2/R9 first address", g_first, e_first);
    chk(g_last == e_last, "R9 last address", g_last, e_last);
    chk(c_rd == e_rd, "R4/R10 rd low clocks", 16'(c_rd), 16'(e_rd));
    chk(c_inst == (v.fetch ? lat : 0), "R11 inst clocks", 16'(c_inst), 16'(v.fetch ? lat : 0));
    if (v.ws) begin
      chk(c_wr == e_wr, "R7 wr low clocks", 16'(c_wr), 16'(e_wr));
      chk(c_bhe == e_bhe, "R7 bhe low clocks", 16'(c_bhe), 16'(e_bhe));
    end else begin
      chk(c_wr == e_wr, "R6 wr low clocks", 16'(c_wr), 16'(e_wr));
      chk(c_bhe == e_bhe, "R6 bhe low clocks", 16'(c_bhe), 16'(e_bhe));
    end
    if (v.wr) begin
      chk(g_oe && g_wd == e_wd, "R5 write data", g_wd, e_wd);
    end else begin
      chk(!g_oe, "R4 bus released", 16'(g_oe), 16'h0);
      chk(rdata_o == e_rdat, "R8/R9 read data", rdata_o, e_rdat);
    end
    @(negedge clk);
    chk(!done_o && !busy_o, "R2 done single pulse", 16'(done_o), 16'h0);
  endtask

  initial begin
    #(8 * 50000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o && !done_o, "R1 reset busy/done", {busy_o, done_o}, 16'h0);
    chk(rd_n_o && wr_n_o && bhe_n_o, "R1 reset strobes high", {rd_n_o, wr_n_o, bhe_n_o}, 16'h7);
    chk(!inst_o && !ad_oe_o, "R1 reset inst/oe", {inst_o, ad_oe_o}, 16'h0);
    chk(as_o == 1'b0, "R1 reset pulse strobe", 16'(as_o), 16'h0);
    cfg_adv = 1; #1;
    chk(as_o == 1'b1, "R1 reset valid-mode strobe", 16'(as_o), 16'h1);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o, "R1 idle without request", 16'(busy_o), 16'h0);
    for (int j = 0; j < NV; j++) run_vec(VECS[j]);
    // R8: fixed 8-bit width ignores the width pin
    run_vec('{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,2'b11,2'd0,16'h0A0A,16'h0000});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule